// File: doc/BRIEF.md
# Descriptor-Driven Crypto Channel Sequencer

This block is one channel of a crypto offload engine. Software writes the address of an in-memory descriptor into the channel's fetch register, and that one write starts the operation. The channel then works on its own. It reads the descriptor one 32-bit word at a time through a bus master port and checks the opcode in the header. It asks the controller for an execution unit. Once it holds a unit, it streams the context (IV) words, the key words and the input data words into that unit. It then writes the unit's output buffer back to memory.

The descriptor is nine consecutive words at the fetch address:

| Offset | Content |
|---|---|
| +0x00 | header; the opcode is in bits [7:0] |
| +0x04 / +0x08 | context byte length / context pointer |
| +0x0C / +0x10 | key byte length / key pointer |
| +0x14 / +0x18 | input byte length / input pointer |
| +0x1C / +0x20 | output byte length / output pointer |

The FSM has these states:

| State | Meaning |
|---|---|
| S_IDLE | waiting for a start |
| S_HDR | reading the header |
| S_PAIRS | reading the eight length/pointer words |
| S_EU_REQ | waiting for an execution-unit grant |
| S_CTX | reading context words |
| S_KEY | reading key words |
| S_DIN | reading input data words |
| S_DOUT | writing output words |
| S_DONE | one-cycle completion |

The transitions are:
- S_IDLE or S_DONE go to S_HDR on an accepted start.
- S_HDR goes to S_PAIRS when the header is acknowledged and its opcode is known.
- S_HDR goes to S_DONE with the error flag set when the header is acknowledged and its opcode is unknown.
- S_PAIRS goes to S_EU_REQ after the eighth pair word is acknowledged.
- S_EU_REQ goes, on grant, to the first stage whose length is non-zero.
- Each stage goes, on its last acknowledged word, to the next stage whose length is non-zero, or to S_DONE if there is none.
- S_DONE goes to S_IDLE when no start is present.

Top module: `crypto_chan_seq`

## Requirements
- R1: A fetch-register write while the channel is not busy starts an operation. `busy_o` rises in the next cycle, and the first master read is at the written address.
- R2: Every master request is one 32-bit word. Descriptor reads run header first, then the eight pair words, at consecutive word addresses from the descriptor pointer.
- R3: The known opcodes in header bits [7:0] are 0x01, 0x02 and 0x03. Any other opcode ends the operation with `done_o` and `err_o` set, after exactly one master read. In that case there is no master write and no unit request.
- R4: `eu_req` is raised after the descriptor is read. No context, key, input or output word moves before `eu_grant` is seen.
- R5: The stages run in the order context, key, input. Each stage reads consecutive words from its pointer. Each word is handed to the unit with `eu_wr_sel` set to 0 for context, 1 for key and 2 for input.
- R6: A byte length that is not a multiple of four is rounded up to whole words.
- R7: A stage whose length is zero is skipped and issues no request.
- R8: The output stage writes words taken from `eu_out_data` to consecutive addresses from the output pointer. It pops one buffer word for each acknowledged write.
- R9: In the cycle after the last acknowledged word, `done_o` pulses for one cycle. In that same cycle `busy_o` and `eu_req` are low.
- R10: A fetch-register write while busy is ignored and sets the sticky `ovr_o`. `ovr_o` clears when the next operation is accepted.
- R11: A master request holds its address and direction stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_wr | input | 1 | Fetch register write strobe |
| fetch_ptr | input | 32 | Descriptor address written with the strobe |
| mst_req | output | 1 | Master request |
| mst_we | output | 1 | Master request is a write |
| mst_addr | output | 32 | Master byte address (word aligned) |
| mst_wdata | output | 32 | Master write data |
| mst_ack | input | 1 | Master acknowledge |
| mst_rdata | input | 32 | Master read data, valid with the acknowledge |
| eu_req | output | 1 | Execution-unit request, held while the unit is owned |
| eu_grant | input | 1 | Execution-unit grant |
| eu_opcode | output | 8 | Opcode passed to the unit |
| eu_wr_valid | output | 1 | Word delivered to the unit |
| eu_wr_sel | output | 2 | Word kind: 0 context, 1 key, 2 input |
| eu_wr_data | output | 32 | Word delivered to the unit |
| eu_out_data | input | 32 | Head of the unit's output buffer |
| eu_out_pop | output | 1 | Pop the output buffer head |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation had an unknown opcode |
| ovr_o | output | 1 | Sticky: a start was attempted while busy |

## Verification
The assertions check several rules on every cycle:
- A pending request keeps its address and direction.
- Unit words and writes only flow while the unit is granted.
- `done_o` lasts a single cycle, with the unit released and `busy_o` low.
- An error run never writes.
- A start attempted while busy raises the overrun flag.

Some behaviour only the directed scenarios can show. These are the exact addresses and their order, the rounding of lengths and the skipping of zero-length stages, the data that reaches the unit and memory, and the fact that a rejected start leaves the running operation untouched.

// File: rtl/crypto_chan_pkg.sv
package crypto_chan_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR,
        S_PAIRS,
        S_EU_REQ,
        S_CTX,
        S_KEY,
        S_DIN,
        S_DOUT,
        S_DONE
    } chan_state_e;

    localparam int NUM_STAGES = 4;

    // stage indices; the first three double as eu_wr_sel codes
    localparam logic [1:0] STG_CTX  = 2'd0;
    localparam logic [1:0] STG_KEY  = 2'd1;
    localparam logic [1:0] STG_DIN  = 2'd2;
    localparam logic [1:0] STG_DOUT = 2'd3;

    localparam logic [7:0] OP_ENC_CTX = 8'h01;
    localparam logic [7:0] OP_DEC_CTX = 8'h02;
    localparam logic [7:0] OP_KEYONLY = 8'h03;

    function automatic logic op_known(input logic [7:0] op);
        return (op == OP_ENC_CTX) || (op == OP_DEC_CTX) || (op == OP_KEYONLY);
    endfunction

    function automatic chan_state_e stage_state(input int idx);
        case (idx)
            0:       return S_CTX;
            1:       return S_KEY;
            2:       return S_DIN;
            default: return S_DOUT;
        endcase
    endfunction

endpackage

// File: rtl/chan_desc_store.sv
module chan_desc_store #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int NSTG   = 4,
    localparam int CNT_W = LEN_W - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NSTG-1:0][CNT_W-1:0]  nwords_o,
    output logic [NSTG-1:0][DATA_W-1:0] ptr_o
);

    for (genvar p = 0; p < NSTG; p++) begin : g_pair
        logic [LEN_W-1:0]  len_q;
        logic [DATA_W-1:0] ptr_q;
        logic [LEN_W:0]    rnd;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_q <= '0;
                ptr_q <= '0;
            end else if (wr_en && wr_idx[2:1] == p[1:0]) begin
                if (wr_idx[0]) ptr_q <= wr_data;
                else           len_q <= wr_data[LEN_W-1:0];
            end
        end

        // byte length rounded up to whole words
        assign rnd         = {1'b0, len_q} + 3;
        assign nwords_o[p] = rnd[LEN_W:2];
        assign ptr_o[p]    = ptr_q;
    end

endmodule

// File: rtl/chan_addr_gen.sv
module chan_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 15
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs = '0;
        offs[CNT_W+1:2] = idx;
    end

    assign addr = base + offs;

endmodule

// File: rtl/crypto_chan_seq.sv
module crypto_chan_seq
    import crypto_chan_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_wr,
    input  logic [31:0] fetch_ptr,
    output logic        mst_req,
    output logic        mst_we,
    output logic [31:0] mst_addr,
    output logic [31:0] mst_wdata,
    input  logic        mst_ack,
    input  logic [31:0] mst_rdata,
    output logic        eu_req,
    input  logic        eu_grant,
    output logic [7:0]  eu_opcode,
    output logic        eu_wr_valid,
    output logic [1:0]  eu_wr_sel,
    output logic [31:0] eu_wr_data,
    input  logic [31:0] eu_out_data,
    output logic        eu_out_pop,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic        ovr_o
);

    localparam int CNT_W  = LEN_W - 1;
    localparam int DATA_W = 32;
    localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(7);

    chan_state_e state_q, state_d;
    logic [CNT_W-1:0]  wcnt_q;
    logic [DATA_W-1:0] desc_q;
    logic [7:0]        op_q;
    logic              err_q, ovr_q;

    logic [NUM_STAGES-1:0][CNT_W-1:0]  nwords;
    logic [NUM_STAGES-1:0][DATA_W-1:0] ptrs;
    chan_state_e       from_stg [NUM_STAGES+1];
    logic [1:0]        cur_stg;
    logic              in_stage, last_word, start_ok;
    logic [DATA_W-1:0] addr_base;
    logic [CNT_W-1:0]  addr_idx;

    assign start_ok = fetch_wr && (state_q == S_IDLE || state_q == S_DONE);

    chan_desc_store #(.DATA_W(DATA_W), .LEN_W(LEN_W), .NSTG(NUM_STAGES)) u_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (state_q == S_PAIRS && mst_ack),
        .wr_idx   (wcnt_q[2:0]),
        .wr_data  (mst_rdata),
        .nwords_o (nwords),
        .ptr_o    (ptrs)
    );

    // first non-empty stage at or after each index
    always_comb begin
        from_stg[NUM_STAGES] = S_DONE;
        for (int i = NUM_STAGES - 1; i >= 0; i--)
            from_stg[i] = (nwords[i] != '0) ? stage_state(i) : from_stg[i+1];
    end

    always_comb begin
        in_stage = 1'b1;
        cur_stg  = STG_CTX;
        unique case (state_q)
            S_CTX:   cur_stg = STG_CTX;
            S_KEY:   cur_stg = STG_KEY;
            S_DIN:   cur_stg = STG_DIN;
            S_DOUT:  cur_stg = STG_DOUT;
            default: in_stage = 1'b0;
        endcase
    end

    assign last_word = mst_ack && (wcnt_q == nwords[cur_stg] - 1'b1);

    always_comb begin
        addr_base = ptrs[cur_stg];
        addr_idx  = wcnt_q;
        if (state_q == S_HDR) begin
            addr_base = desc_q;
            addr_idx  = '0;
        end else if (state_q == S_PAIRS) begin
            addr_base = desc_q + 32'd4;
        end
    end

    chan_addr_gen #(.ADDR_W(DATA_W), .CNT_W(CNT_W)) u_addr (
        .base (addr_base),
        .idx  (addr_idx),
        .addr (mst_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_ok) state_d = S_HDR;
            S_HDR:    if (mst_ack)
                          state_d = op_known(mst_rdata[7:0]) ? S_PAIRS : S_DONE;
            S_PAIRS:  if (mst_ack && wcnt_q == LAST_PAIR) state_d = S_EU_REQ;
            S_EU_REQ: if (eu_grant) state_d = from_stg[0];
            S_CTX:    if (last_word) state_d = from_stg[1];
            S_KEY:    if (last_word) state_d = from_stg[2];
            S_DIN:    if (last_word) state_d = from_stg[3];
            S_DOUT:   if (last_word) state_d = S_DONE;
            S_DONE:   state_d = start_ok ? S_HDR : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            desc_q <= '0;
            op_q   <= '0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (start_ok) begin
                desc_q <= fetch_ptr;
                err_q  <= 1'b0;
                ovr_q  <= 1'b0;
            end else if (fetch_wr) begin
                ovr_q  <= 1'b1;
            end
            if (state_q == S_HDR && mst_ack) begin
                op_q  <= mst_rdata[7:0];
                err_q <= !op_known(mst_rdata[7:0]);
            end
            if (state_d != state_q)                     wcnt_q <= '0;
            else if (mst_ack && state_q != S_HDR)       wcnt_q <= wcnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mst_req     = 1'b0;
        mst_we      = 1'b0;
        eu_req      = 1'b0;
        eu_wr_valid = 1'b0;
        eu_out_pop  = 1'b0;
        unique case (state_q)
            S_HDR, S_PAIRS:      mst_req = 1'b1;
            S_EU_REQ:            eu_req  = 1'b1;
            S_CTX, S_KEY, S_DIN: begin
                mst_req     = 1'b1;
                eu_req      = 1'b1;
                eu_wr_valid = mst_ack;
            end
            S_DOUT: begin
                mst_req    = 1'b1;
                mst_we     = 1'b1;
                eu_req     = 1'b1;
                eu_out_pop = mst_ack;
            end
            default: ;
        endcase
    end

    assign mst_wdata  = eu_out_data;
    assign eu_wr_sel  = cur_stg;
    assign eu_wr_data = mst_rdata;
    assign eu_opcode  = op_q;
    assign busy_o     = !(state_q == S_IDLE || state_q == S_DONE);
    assign done_o     = (state_q == S_DONE);
    assign err_o      = err_q;
    assign ovr_o      = ovr_q;

    // ---------------- assertions ----------------
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req && !mst_ack |=> mst_req && $stable(mst_addr) && $stable(mst_we));

    p_stage_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_stage |-> eu_grant);

    p_write_needs_unit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req && mst_we |-> eu_req && eu_grant);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o || $past(fetch_wr));

    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !eu_req);

    p_err_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !(mst_req && mst_we));

    p_overrun_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && fetch_wr |=> ovr_o);

    p_stage_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_stage |-> wcnt_q < nwords[cur_stg]);

endmodule

// File: tb/crypto_chan_seq_tb_top.sv
module crypto_chan_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_wr = 1'b0;
    logic [31:0] fetch_ptr = '0;
    logic        mst_req, mst_we, mst_ack;
    logic [31:0] mst_addr, mst_wdata, mst_rdata;
    logic        eu_req, eu_grant, eu_wr_valid, eu_out_pop;
    logic [7:0]  eu_opcode;
    logic [1:0]  eu_wr_sel;
    logic [31:0] eu_wr_data, eu_out_data;
    logic        busy_o, done_o, err_o, ovr_o;

    always #10 clk = ~clk;

    crypto_chan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_wr(fetch_wr), .fetch_ptr(fetch_ptr),
        .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr),
        .mst_wdata(mst_wdata), .mst_ack(mst_ack), .mst_rdata(mst_rdata),
        .eu_req(eu_req), .eu_grant(eu_grant), .eu_opcode(eu_opcode),
        .eu_wr_valid(eu_wr_valid), .eu_wr_sel(eu_wr_sel), .eu_wr_data(eu_wr_data),
        .eu_out_data(eu_out_data), .eu_out_pop(eu_out_pop),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ovr_o(ovr_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // ---------------- memory and unit models ----------------
    logic [31:0] mem [64];
    logic [31:0] pop_cnt;

    assign mst_rdata   = mem[mst_addr[7:2]];
    assign eu_out_data = 32'hA000_0000 | pop_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_ack  <= 1'b0;
            eu_grant <= 1'b0;
            pop_cnt  <= '0;
        end else begin
            mst_ack  <= mst_req && !mst_ack;
            eu_grant <= eu_req;
            if (mst_req && mst_we && mst_ack) mem[mst_addr[7:2]] <= mst_wdata;
            if (eu_out_pop) pop_cnt <= pop_cnt + 1;
        end
    end

    // ---------------- monitor ----------------
    int          n_rd, n_wr, n_done, n_eu;
    int          n_sel [3];
    logic [31:0] got [3][8];
    logic [31:0] rd_addr [32];
    logic [31:0] wr_addr [8];
    int          last_sel;
    bit          order_bad, ungranted;

    task automatic clear_mon();
        n_rd = 0; n_wr = 0; n_done = 0; n_eu = 0;
        for (int i = 0; i < 3; i++) n_sel[i] = 0;
        last_sel = 0; order_bad = 0; ungranted = 0;
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (mst_req && mst_ack && !mst_we) begin
                if (n_rd < 32) rd_addr[n_rd] = mst_addr;
                n_rd++;
            end
            if (mst_req && mst_ack && mst_we) begin
                if (n_wr < 8) wr_addr[n_wr] = mst_addr;
                n_wr++;
                if (!eu_grant) ungranted = 1;
            end
            if (eu_wr_valid) begin
                if (!eu_grant) ungranted = 1;
                if (int'(eu_wr_sel) < last_sel) order_bad = 1;
                last_sel = int'(eu_wr_sel);
                if (eu_wr_sel < 3 && n_sel[eu_wr_sel] < 8)
                    got[eu_wr_sel][n_sel[eu_wr_sel]] = eu_wr_data;
                if (eu_wr_sel < 3) n_sel[eu_wr_sel]++;
            end
            if (done_o) n_done++;
            if (eu_req) n_eu++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int w, input logic [7:0] op,
                            input logic [31:0] lc, input logic [31:0] pc,
                            input logic [31:0] lk, input logic [31:0] pk,
                            input logic [31:0] li, input logic [31:0] pi,
                            input logic [31:0] lo, input logic [31:0] po);
        mem[w]   = {24'h5A5A00, op};
        mem[w+1] = lc; mem[w+2] = pc;
        mem[w+3] = lk; mem[w+4] = pk;
        mem[w+5] = li; mem[w+6] = pi;
        mem[w+7] = lo; mem[w+8] = po;
    endtask

    task automatic start(input logic [31:0] ptr);
        @(negedge clk);
        clear_mon();
        fetch_wr = 1'b1; fetch_ptr = ptr;
        @(negedge clk);
        fetch_wr = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (n_done == 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("reset busy", busy_o, 0);
        chk("reset done", done_o, 0);
        chk("reset req", mst_req, 0);
        chk("reset eu_req", eu_req, 0);
        chk("reset err/ovr", {err_o, ovr_o}, 0);
    endtask

    task automatic t_full_run();
        logic [31:0] base;
        put_desc(0, 8'h01, 8, 32'h40, 16, 32'h60, 6, 32'h80, 8, 32'hC0);
        base = pop_cnt;
        start(32'h0);
        chk("R1 busy after start", busy_o, 1);
        wait_done();
        chk("R1 first read at pointer", rd_addr[0], 32'h0);
        for (int i = 1; i < 9; i++) chk("R2 pair word address", rd_addr[i], 32'(i * 4));
        chk("R2 total reads", n_rd, 17);
        chk("R5 ctx word count", n_sel[0], 2);
        chk("R5 key word count", n_sel[1], 4);
        chk("R6 input 6 bytes -> 2 words", n_sel[2], 2);
        for (int i = 0; i < 2; i++) chk("R5 ctx data", got[0][i], mem[16 + i]);
        for (int i = 0; i < 4; i++) chk("R5 key data", got[1][i], mem[24 + i]);
        for (int i = 0; i < 2; i++) chk("R6 input data", got[2][i], mem[32 + i]);
        chk("R5 stage order", order_bad, 0);
        chk("R4 unit granted for data", ungranted, 0);
        chk("R4 opcode to unit", eu_opcode, 8'h01);
        chk("R8 write count", n_wr, 2);
        chk("R8 write addr 0", wr_addr[0], 32'hC0);
        chk("R8 write addr 1", wr_addr[1], 32'hC4);
        chk("R8 out word 0", mem[48], 32'hA000_0000 | base);
        chk("R8 out word 1", mem[49], 32'hA000_0000 | (base + 1));
        chk("R9 single done pulse", n_done, 1);
        chk("R9 released after done", {busy_o, eu_req}, 0);
        chk("R3 no error", err_o, 0);
    endtask

    task automatic t_zero_skip();
        put_desc(9, 8'h02, 0, 32'h40, 4, 32'h60, 0, 32'h80, 4, 32'hD0);
        start(32'h24);
        chk("R10 overrun cleared on start", ovr_o, 0);
        wait_done();
        chk("R7 no ctx words", n_sel[0], 0);
        chk("R7 one key word", n_sel[1], 1);
        chk("R7 no input words", n_sel[2], 0);
        chk("R7 reads = 9 + 1", n_rd, 10);
        chk("R7 one write", n_wr, 1);
        chk("R8 write at out ptr", wr_addr[0], 32'hD0);
    endtask

    task automatic t_bad_op();
        mem[18] = 32'h0000_007F;
        start(32'h48);
        wait_done();
        chk("R3 error flag", err_o, 1);
        chk("R3 single read", n_rd, 1);
        chk("R3 no write", n_wr, 0);
        chk("R3 no unit request", n_eu, 0);
        chk("R3 done pulse", n_done, 1);
    endtask

    task automatic t_overrun();
        put_desc(0, 8'h03, 8, 32'h40, 16, 32'h60, 6, 32'h80, 8, 32'hC0);
        start(32'h0);
        repeat (5) @(negedge clk);
        fetch_wr = 1'b1; fetch_ptr = 32'h24;
        @(negedge clk);
        fetch_wr = 1'b0;
        chk("R10 overrun set", ovr_o, 1);
        chk("R10 still busy", busy_o, 1);
        wait_done();
        chk("R10 rejected start had no effect", n_rd, 17);
        chk("R10 done once", n_done, 1);
        chk("R10 overrun sticky", ovr_o, 1);
        chk("R3 cleared by new start", err_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h1111_0000 + 32'(i);
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_full_run();
        t_bad_op();
        t_overrun();
        t_zero_skip();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule